// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator Bank

This block turns compare-channel levels from a PWM timer into complementary pin pairs for half-bridge drivers. Each generator registers its input level. The low-side output follows that registered level and the high-side output is its inverse. On every change of the input level, both sides are held off for a programmable number of clock cycles, so the two transistors of a bridge leg are never on together.

The dead time for a rising input edge and the dead time for a falling input edge are set separately. All generators in the bank share the same pair of settings. Generator g drives pin g and pin NUM_GEN+g. A per-generator swap control exchanges the roles of those two pins after the gating. A per-generator enable bypasses dead-time insertion when it is cleared.

Top module: `dtg_bank`

## Requirements
- R1: While reset is held, every generator's level register and counter are set to zero. After reset with the inputs low, each enabled, unswapped generator drives its low-side pin to 0 and its high-side pin to 1.
- R2: Outside dead time, the low-side pin of generator g equals the input level sampled at the previous clock edge, and the high-side pin equals its inverse.
- R3: When the clock edge samples a 0-to-1 change of the input, the counter is loaded from `dt_rise`. Both pins of the pair stay 0 for exactly `dt_rise` cycles after that edge, and the low side goes to 1 on the next edge.
- R4: When the clock edge samples a 1-to-0 change of the input, the counter is loaded from `dt_fall`. Both pins stay 0 for exactly `dt_fall` cycles, and then the high side goes to 1.
- R5: The 8-bit counter decreases by one per clock and holds at zero. The largest value, 255, gives 255 blanked cycles.
- R6: A dead-time value of 0 gives no blanking: the pins switch at the first clock edge that samples the new level.
- R7: An input edge that arrives while the counter is non-zero reloads the counter from the value for the new edge direction. The blanking then restarts from that value.
- R8: Pin g (bits 0 to NUM_GEN-1 of `pin_out`) is the low side of generator g, and pin NUM_GEN+g is its high side. All generators use the same `dt_rise` and `dt_fall`.
- R9: When `swap_en[g]` is 1, pin g carries the high side and pin NUM_GEN+g carries the low side.
- R10: When `gen_en[g]` is 0, the counter of generator g is held at zero and its pins follow the registered level and its inverse with no blanking.
- R11: The two pins of a pair are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_lvl | input | NUM_GEN | Compare-channel level for each generator |
| gen_en | input | NUM_GEN | Dead-time insertion enable for each generator |
| swap_en | input | NUM_GEN | Pin-pair swap for each generator |
| dt_rise | input | CNT_W | Dead-time cycles loaded on a rising input edge |
| dt_fall | input | CNT_W | Dead-time cycles loaded on a falling input edge |
| pin_out | output | 2*NUM_GEN | Pins: low sides in the lower half, high sides in the upper half |

## Verification
Rising and falling edges are driven with different dead-time values. This shows whether each edge direction loads its own setting and whether the blanking lasts exactly that many cycles. Zero and 255 values probe both ends of the counter range. An edge placed in the middle of a countdown separates a restart from a continuation of the old count. All four inputs switching together checks the shared settings and pin placement. Separate swap and bypass patterns show the pin exchange and the unblanked path.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

    typedef struct packed {
        logic lo;
        logic hi;
    } side_pair_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_t;

    function automatic edge_kind_t classify_edge(input logic now_lvl, input logic old_lvl);
        if (now_lvl && !old_lvl)      return EDGE_RISE;
        else if (!now_lvl && old_lvl) return EDGE_FALL;
        else                          return EDGE_NONE;
    endfunction

    // first field -> pin g, second field -> pin NUM_GEN+g
    function automatic side_pair_t place_pins(input side_pair_t sides, input logic swap);
        side_pair_t p;
        p.lo = swap ? sides.hi : sides.lo;
        p.hi = swap ? sides.lo : sides.hi;
        return p;
    endfunction

endpackage

// File: rtl/dtg_edge_counter.sv
`timescale 1ns/1ps
module dtg_edge_counter
    import dtg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             lvl,
    input  logic [CNT_W-1:0] dt_rise,
    input  logic [CNT_W-1:0] dt_fall,
    output logic             lvl_q,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;
    edge_kind_t       edge_k;

    assign edge_k = classify_edge(lvl, lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt   <= '0;
        end else begin
            lvl_q <= lvl;
            if (!en) begin
                cnt <= '0;
            end else begin
                case (edge_k)
                    EDGE_RISE: cnt <= dt_rise;
                    EDGE_FALL: cnt <= dt_fall;
                    default:   if (cnt != '0) cnt <= cnt - 1'b1;
                endcase
            end
        end
    end

    assign busy = (cnt != '0);

    assert_rise_load_R3: assert property (@(posedge clk) disable iff (rst)
        (en && lvl && !lvl_q) |=> (cnt == $past(dt_rise)));

    assert_fall_load_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !lvl && lvl_q) |=> (cnt == $past(dt_fall)));

    assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
        (en && (lvl == lvl_q) && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (en && (lvl == lvl_q) && (cnt == '0)) |=> (cnt == '0));

    assert_bypass_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));
endmodule

// File: rtl/dtg_gate.sv
`timescale 1ns/1ps
module dtg_gate
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       lvl_q,
    input  logic       busy,
    output side_pair_t drive
);
    always_comb begin
        drive.lo = lvl_q;
        drive.hi = !lvl_q;
        if (en && busy) drive = '0;
    end

    assert_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (en && busy) |-> (!drive.lo && !drive.hi));

    assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (drive.lo == lvl_q));
endmodule

// File: rtl/dtg_slice.sv
`timescale 1ns/1ps
module dtg_slice
    import dtg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             swap,
    input  logic             lvl,
    input  logic [CNT_W-1:0] dt_rise,
    input  logic [CNT_W-1:0] dt_fall,
    output side_pair_t       pins
);
    logic       lvl_q;
    logic       busy;
    side_pair_t drive;

    dtg_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .lvl(lvl),
        .dt_rise(dt_rise), .dt_fall(dt_fall),
        .lvl_q(lvl_q), .busy(busy)
    );

    dtg_gate u_gate (
        .clk(clk), .rst(rst), .en(en), .lvl_q(lvl_q), .busy(busy), .drive(drive)
    );

    assign pins = place_pins(drive, swap);
endmodule

// File: rtl/dtg_bank.sv
`timescale 1ns/1ps
module dtg_bank
    import dtg_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_GEN-1:0]   chan_lvl,
    input  logic [NUM_GEN-1:0]   gen_en,
    input  logic [NUM_GEN-1:0]   swap_en,
    input  logic [CNT_W-1:0]     dt_rise,
    input  logic [CNT_W-1:0]     dt_fall,
    output logic [2*NUM_GEN-1:0] pin_out
);
    localparam int PIN_N = 2 * NUM_GEN;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_slice
        side_pair_t pins;

        dtg_slice #(.CNT_W(CNT_W)) u_slice (
            .clk(clk), .rst(rst), .en(gen_en[g]), .swap(swap_en[g]),
            .lvl(chan_lvl[g]), .dt_rise(dt_rise), .dt_fall(dt_fall),
            .pins(pins)
        );

        assign pin_out[g]             = pins.lo;
        assign pin_out[PIN_N/2 + g]   = pins.hi;

        assert_pair_excl_R11: assert property (@(posedge clk) disable iff (rst)
            !(pin_out[g] && pin_out[PIN_N/2 + g]));
    end
endmodule

// File: tb/test_dtg_bank.sv
`timescale 1ns/1ps
module test_dtg_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] chan_lvl;
    logic [3:0] gen_en;
    logic [3:0] swap_en;
    logic [7:0] dt_rise;
    logic [7:0] dt_fall;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dtg_bank i_dtg_bank (
        .clk(clk), .rst(rst), .chan_lvl(chan_lvl), .gen_en(gen_en),
        .swap_en(swap_en), .dt_rise(dt_rise), .dt_fall(dt_fall), .pin_out(pin_out)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [7:0] pins(input logic [3:0] lo, input logic [3:0] hi,
                                        input logic [3:0] sw);
        logic [7:0] v;
        for (int g = 0; g < 4; g++) begin
            v[g]   = sw[g] ? hi[g] : lo[g];
            v[4+g] = sw[g] ? lo[g] : hi[g];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] exp);
        checks++;
        if (pin_out !== exp) begin
            errors++;
            $display("FAIL %s pin_out=%b expected %b", tag, pin_out, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; chan_lvl = 4'h0; gen_en = 4'hF; swap_en = 4'h0;
        dt_rise = 8'd3; dt_fall = 8'd2;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset state", pins(4'h0, 4'hF, 4'h0));
    endtask

    task automatic t_rise;
        chan_lvl = 4'b0001;
        for (int k = 1; k <= 3; k++) begin
            tick(1);
            chk("R3 rise blank", pins(4'b0000, 4'b1110, 4'h0));
        end
        tick(1);
        chk("R3 R2 low side on", pins(4'b0001, 4'b1110, 4'h0));
    endtask

    task automatic t_fall;
        chan_lvl = 4'b0000;
        for (int k = 1; k <= 2; k++) begin
            tick(1);
            chk("R4 fall blank", pins(4'b0000, 4'b1110, 4'h0));
        end
        tick(1);
        chk("R4 R2 high side on", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_zero;
        dt_rise = 8'd0; dt_fall = 8'd0;
        chan_lvl = 4'b1010;
        tick(1);
        chk("R6 zero rise", pins(4'b1010, 4'b0101, 4'h0));
        chan_lvl = 4'b0000;
        tick(1);
        chk("R6 zero fall", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_max;
        int bad = 0;
        dt_rise = 8'd255; dt_fall = 8'd1;
        chan_lvl = 4'b0001;
        for (int k = 1; k <= 255; k++) begin
            tick(1);
            if (pin_out !== pins(4'b0000, 4'b1110, 4'h0)) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R5 max blank: %0d bad cycles expected 0", bad);
        end
        tick(1);
        chk("R5 on after 255", pins(4'b0001, 4'b1110, 4'h0));
        chan_lvl = 4'b0000;
        tick(1);
        chk("R5 fall one", pins(4'b0000, 4'b1110, 4'h0));
        tick(1);
        chk("R5 fall done", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_restart;
        dt_rise = 8'd10; dt_fall = 8'd4;
        chan_lvl = 4'b0001;
        tick(3);
        chk("R7 mid count", pins(4'b0000, 4'b1110, 4'h0));
        chan_lvl = 4'b0000;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            chk("R7 restart blank", pins(4'b0000, 4'b1110, 4'h0));
        end
        tick(1);
        chk("R7 restart done", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_shared;
        dt_rise = 8'd2; dt_fall = 8'd0;
        chan_lvl = 4'b1111;
        tick(2);
        chk("R8 all blank", pins(4'b0000, 4'b0000, 4'h0));
        tick(1);
        chk("R8 all on", pins(4'b1111, 4'b0000, 4'h0));
        chan_lvl = 4'b0000;
        tick(1);
        chk("R8 all back", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_swap;
        dt_rise = 8'd0; dt_fall = 8'd0;
        swap_en = 4'b0100;
        tick(1);
        chk("R9 swap idle", 8'b1011_0100);
        chan_lvl = 4'b0100;
        tick(1);
        chk("R9 swap driven", 8'b1111_0000);
        chan_lvl = 4'b0000;
        swap_en = 4'b0000;
        tick(1);
        chk("R9 unswapped", pins(4'b0000, 4'b1111, 4'h0));
    endtask

    task automatic t_bypass;
        dt_rise = 8'd5; dt_fall = 8'd5;
        gen_en = 4'b1110;
        chan_lvl = 4'b0001;
        tick(1);
        chk("R10 bypass rise", pins(4'b0001, 4'b1110, 4'h0));
        gen_en = 4'b1111;
        tick(1);
        chk("R10 re-enable no blank", pins(4'b0001, 4'b1110, 4'h0));
        gen_en = 4'b1110;
        chan_lvl = 4'b0000;
        tick(1);
        chk("R10 bypass fall", pins(4'b0000, 4'b1111, 4'h0));
        gen_en = 4'b1111;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_zero();
        t_max();
        t_restart();
        t_shared();
        t_swap();
        t_bypass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule